// File: doc/BRIEF.md
# Loss-of-Signal Pulse Density Recovery

This block decides when an active loss-of-signal alarm on a received line may be withdrawn. The line receiver supplies one mark indication per bit period, qualified by a bit-clock enable, and a separate detector raises an assert strobe whenever it declares loss of signal. While the alarm is up, the block waits for a mark. That first mark opens a measurement window of programmable length and counts as its first mark. The alarm drops only if enough marks arrive before the window closes.

The required mark count is one more than an 8-bit threshold value, so a threshold of 0 needs a single mark and a threshold of 255 needs 256. The window length comes from a second 8-bit value: it spans (value + 1) × 16 bit periods, which gives 16 to 4096. If a window closes without enough marks, the block does not restart the window at once. It waits for the next mark before opening a new window. Once the alarm is cleared, the block stays idle until the detector asserts again.

Top module: `los_density_recovery`

## Requirements
- R1: Synchronous active-high reset drives `los_flag` low and leaves the block idle, so marks that arrive without an assert strobe keep `los_flag` low.
- R2: `los_set` high in any cycle makes `los_flag` 1 after the next clock edge. It abandons any window in progress, so marks counted before the strobe do not count toward clearing.
- R3: While the alarm is active and no window is open, bit periods without a mark start nothing. The window opens on the first bit period whose `mark_in` is 1, and that mark counts as mark number one.
- R4: Within an open window, once the number of marks reaches `thresh` + 1, `los_flag` goes to 0. The change is visible after the same clock edge that samples the qualifying mark.
- R5: A window lasts (`win_len` + 1) × 16 bit periods, counting the opening bit. A mark in the last of those bit periods still counts. If fewer than `thresh` + 1 marks arrive in the window, the alarm stays active.
- R6: After a failed window, no window runs until the next mark, which opens a new window with a count of one.
- R7: With `thresh` = 0, a single mark clears the alarm.
- R8: With `thresh` = 255, exactly 256 marks are needed. The mark counter saturates at 256 and never wraps, and a window of 4096 bit periods (`win_len` = 255) is supported.
- R9: Cycles with `bit_en` low are ignored. `mark_in` has no effect in those cycles, and they do not advance the window.
- R10: After the alarm clears, `los_flag` stays low and marks have no effect until `los_set` is asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe marking a received bit period |
| mark_in | input | 1 | Mark (pulse) seen in this bit period; valid when `bit_en` is high |
| los_set | input | 1 | Alarm assert from the loss-of-signal detector |
| thresh | input | 8 | Threshold N; N + 1 marks are needed to clear |
| win_len | input | 8 | Window length W; the window is (W + 1) × 16 bit periods |
| los_flag | output | 1 | Registered loss-of-signal alarm |

## Verification
The hardest case to reach from the ports is telling a window that opens on the next mark apart from one that restarts as soon as the previous window fails. The stimulus handles this with a failed window followed by a run of empty bits. It then sends one mark, then more empty bits that run past where a free-running window would have closed, and then the remaining marks. Only a window anchored on that lone mark clears the alarm. A second stimulus places the qualifying mark exactly in the last bit of a window, and also one bit past the end, to pin down the window length.

// File: rtl/los_rec_pkg.sv
package los_rec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_MEAS  = 2'd2
  } los_st_e;
endpackage

// File: rtl/los_pulse_ctr.sv
module los_pulse_ctr #(
  parameter int W        = 9,
  parameter int MAXV     = 256,
  parameter bit SATURATE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         start,
  input  logic         step,
  output logic [W-1:0] cnt_nx
);
  localparam logic [W-1:0] TOP = W'(MAXV);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_inc;

  generate
    if (SATURATE) begin : g_sat
      assign cnt_inc = (cnt_q >= TOP) ? TOP : cnt_q + 1'b1;
    end else begin : g_wrap
      assign cnt_inc = cnt_q + 1'b1;
    end
  endgenerate

  always_comb begin
    if (clr)        cnt_nx = '0;
    else if (start) cnt_nx = W'(1);
    else if (step)  cnt_nx = cnt_inc;
    else            cnt_nx = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/los_win_timer.sv
module los_win_timer #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         start,
  input  logic         tick,
  output logic [W-1:0] tim_nx
);
  logic [W-1:0] tim_q;

  always_comb begin
    if (clr)        tim_nx = '0;
    else if (start) tim_nx = W'(1);
    else if (tick)  tim_nx = tim_q + 1'b1;
    else            tim_nx = tim_q;
  end

  always_ff @(posedge clk) begin
    if (rst) tim_q <= '0;
    else     tim_q <= tim_nx;
  end
endmodule

// File: rtl/los_density_recovery.sv
module los_density_recovery
  import los_rec_pkg::*;
#(
  parameter int TH_W      = 8,
  parameter int WL_W      = 8,
  parameter int WIN_SHIFT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_en,
  input  logic            mark_in,
  input  logic            los_set,
  input  logic [TH_W-1:0] thresh,
  input  logic [WL_W-1:0] win_len,
  output logic            los_flag
);
  localparam int CNT_W   = TH_W + 1;
  localparam int CNT_MAX = 1 << TH_W;
  localparam int TIM_W   = WL_W + WIN_SHIFT + 1;

  los_st_e          st_q;
  logic             in_win;
  logic             armed;
  logic             open_win;
  logic             step;
  logic             hit;
  logic             win_end;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W-1:0] need;
  logic [TIM_W-1:0] tim_nx;
  logic [TIM_W-1:0] win_lim;

  assign in_win   = (st_q == ST_MEAS);
  assign armed    = (st_q == ST_ARMED);
  assign open_win = armed && bit_en && mark_in && !los_set;
  assign step     = in_win && bit_en && !los_set;
  assign need     = CNT_W'(thresh) + 1'b1;
  assign win_lim  = (TIM_W'(win_len) + 1'b1) << WIN_SHIFT;
  assign hit      = (cnt_nx >= need);
  assign win_end  = (tim_nx == win_lim);

  los_pulse_ctr #(
    .W(CNT_W), .MAXV(CNT_MAX), .SATURATE(1'b1)
  ) u_ctr (
    .clk(clk), .rst(rst), .clr(los_set), .start(open_win),
    .step(step && mark_in), .cnt_nx(cnt_nx)
  );

  los_win_timer #(
    .W(TIM_W)
  ) u_tim (
    .clk(clk), .rst(rst), .clr(los_set), .start(open_win),
    .tick(step), .tim_nx(tim_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      los_flag <= 1'b0;
    end else if (los_set) begin
      st_q     <= ST_ARMED;
      los_flag <= 1'b1;
    end else begin
      case (st_q)
        ST_ARMED: begin
          if (open_win) begin
            if (hit) begin
              st_q     <= ST_IDLE;
              los_flag <= 1'b0;
            end else begin
              st_q <= ST_MEAS;
            end
          end
        end
        ST_MEAS: begin
          if (step) begin
            if (hit) begin
              st_q     <= ST_IDLE;
              los_flag <= 1'b0;
            end else if (win_end) begin
              st_q <= ST_ARMED;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/los_recovery_chk.sv
module los_recovery_chk #(
  parameter int CNT_W   = 9,
  parameter int CNT_MAX = 256,
  parameter int TIM_W   = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic             mark_in,
  input logic             los_set,
  input logic             los_flag,
  input logic             in_win,
  input logic [CNT_W-1:0] cnt_nx,
  input logic [TIM_W-1:0] tim_nx,
  input logic [TIM_W-1:0] win_lim
);
  // R2
  set_next_chk: assert property (@(posedge clk) disable iff (rst)
    los_set |=> los_flag);

  // R4
  clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(los_flag) |-> $past(bit_en && mark_in && !los_set));

  // R10
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(los_flag) |-> $past(los_set));

  // R9
  idle_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && !los_set) |=> $stable(los_flag));

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_nx <= CNT_W'(CNT_MAX));

  // R5
  win_range_chk: assert property (@(posedge clk) disable iff (rst)
    in_win |-> (tim_nx <= win_lim));
endmodule

bind los_density_recovery los_recovery_chk #(
  .CNT_W(CNT_W), .CNT_MAX(CNT_MAX), .TIM_W(TIM_W)
) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .mark_in(mark_in),
  .los_set(los_set), .los_flag(los_flag), .in_win(in_win),
  .cnt_nx(cnt_nx), .tim_nx(tim_nx), .win_lim(win_lim)
);

// File: tb/sim_los_density_recovery.sv
module sim_los_density_recovery;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       mark_in = 1'b0;
  logic       los_set = 1'b0;
  logic [7:0] thresh = 8'd0;
  logic [7:0] win_len = 8'd0;
  logic       los_flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  los_density_recovery u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .mark_in(mark_in),
    .los_set(los_set), .thresh(thresh), .win_len(win_len),
    .los_flag(los_flag)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (los_flag !== exp) begin
      errors++;
      $display("FAIL %s: los_flag=%b expected=%b", req, los_flag, exp);
    end
  endtask

  task automatic put_bit(input logic m, input int gap);
    @(negedge clk); bit_en = 1'b1; mark_in = m;
    @(negedge clk); bit_en = 1'b0; mark_in = 1'b1;
    repeat (gap) @(negedge clk);
    mark_in = 1'b0;
  endtask

  task automatic put_bits(input logic m, input int n);
    for (int i = 0; i < n; i++) put_bit(m, 0);
  endtask

  task automatic arm(input logic [7:0] n, input logic [7:0] w);
    thresh = n; win_len = w;
    @(negedge clk); los_set = 1'b1;
    @(negedge clk); los_set = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1'b0, "R1 after reset");
    put_bits(1'b1, 5);
    check(1'b0, "R1 marks without assert");
  endtask

  task automatic t_basic;
    arm(8'd3, 8'd0);
    check(1'b1, "R2 assert sets flag");
    put_bits(1'b0, 40);
    check(1'b1, "R3 empty bits open nothing");
    put_bit(1'b1, 0); put_bit(1'b0, 0); put_bit(1'b1, 0); put_bit(1'b0, 0);
    put_bit(1'b1, 0);
    check(1'b1, "R4 three of four marks");
    put_bit(1'b1, 0);
    check(1'b0, "R4 fourth mark clears");
  endtask

  task automatic t_edge_of_window;
    arm(8'd3, 8'd0);
    put_bits(1'b1, 3);
    put_bits(1'b0, 12);
    put_bit(1'b1, 0);
    check(1'b0, "R5 mark in last window bit counts");
    arm(8'd3, 8'd0);
    put_bits(1'b1, 3);
    put_bits(1'b0, 13);
    check(1'b1, "R5 window failed");
    put_bit(1'b1, 0);
    check(1'b1, "R5 mark after window end does not clear");
  endtask

  task automatic t_restart;
    arm(8'd3, 8'd0);
    put_bits(1'b1, 3);
    put_bits(1'b0, 13);
    put_bits(1'b0, 10);
    put_bit(1'b1, 0);
    put_bits(1'b0, 6);
    put_bits(1'b1, 2);
    check(1'b1, "R6 three marks in new window");
    put_bit(1'b1, 0);
    check(1'b0, "R6 window anchored on next mark");
  endtask

  task automatic t_single;
    arm(8'd0, 8'd0);
    put_bits(1'b0, 5);
    check(1'b1, "R7 waiting for mark");
    put_bit(1'b1, 0);
    check(1'b0, "R7 one mark clears");
  endtask

  task automatic t_abandon;
    arm(8'd3, 8'd0);
    put_bits(1'b1, 3);
    arm(8'd3, 8'd0);
    put_bit(1'b1, 0);
    check(1'b1, "R2 window abandoned on assert");
    put_bits(1'b1, 3);
    check(1'b0, "R2 fresh count clears");
  endtask

  task automatic t_max;
    arm(8'd255, 8'd255);
    put_bits(1'b1, 255);
    check(1'b1, "R8 255 marks not enough");
    put_bit(1'b1, 0);
    check(1'b0, "R8 256th mark clears");
    arm(8'd1, 8'd255);
    put_bit(1'b1, 0);
    put_bits(1'b0, 4094);
    put_bit(1'b1, 0);
    check(1'b0, "R8 mark at bit 4096 counts");
    arm(8'd1, 8'd255);
    put_bit(1'b1, 0);
    put_bits(1'b0, 4095);
    put_bit(1'b1, 0);
    check(1'b1, "R8 mark at bit 4097 opens new window");
  endtask

  task automatic t_gaps;
    arm(8'd2, 8'd0);
    put_bit(1'b1, 5); put_bit(1'b1, 5);
    check(1'b1, "R9 marks while bit_en low ignored");
    put_bit(1'b1, 3);
    check(1'b0, "R9 third real mark clears");
    arm(8'd1, 8'd0);
    put_bit(1'b1, 4);
    for (int i = 0; i < 14; i++) put_bit(1'b0, 2);
    put_bit(1'b1, 0);
    check(1'b0, "R9 idle cycles do not advance window");
  endtask

  task automatic t_stay_clear;
    put_bits(1'b1, 20);
    check(1'b0, "R10 stays clear");
    arm(8'd0, 8'd0);
    check(1'b1, "R10 reassert");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_edge_of_window();
    t_restart();
    t_single();
    t_abandon();
    t_max();
    t_gaps();
    t_stay_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule